// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block takes one group of sixteen lane addresses, each with its own active bit, along with a code for the word size. From them it produces the smallest set of aligned memory segment transactions that covers every active lane. Each transaction is presented on a valid/ready output as a segment base address, a size in bytes and a mask of the lanes it serves. When the last transaction of a group has been accepted, a one-cycle completion pulse follows. The block then takes the next group.

A mode bit chooses between two coalescing rules. The strict rule gives a single segment only when each active lane k reads word k of one aligned block of sixteen words. Any other pattern falls back to one word-sized transaction per active lane. The relaxed rule accepts any pattern and emits one transaction for each distinct segment the active lanes touch, in ascending address order.

Top module: `lane_coalescer`

## Requirements
- R1: After reset, req_ready is 1, txn_valid is 0 and done is 0.
- R2: The word size code maps as 0→1 byte, 1→2, 2→4, 3→8, 4→16, and codes 5 to 7 act as 16. A segment spans sixteen words, capped at 128 bytes, so segments are 16, 32, 64, 128 and 128 bytes. Address bits below the word size are ignored.
- R3: In relaxed mode (req_relaxed=1), one transaction is issued per distinct segment touched by the active lanes, in ascending base order. Each has txn_bytes equal to the segment size and txn_mask holding exactly the active lanes in that segment (bit k = lane k).
- R4: In strict mode (req_relaxed=0), when every active lane k addresses word k of one block of sixteen words aligned to sixteen words, the output is the same as in R3. That is one transaction, or two 128-byte halves for 16-byte words.
- R5: In strict mode, any other pattern (a permutation or a misaligned base) gives one transaction per active lane in ascending lane order. Each has the lane address rounded down to the word size, txn_bytes equal to the word size and a one-hot mask.
- R6: Inactive lanes never show up in any mask and do not affect whether strict coalescing succeeds.
- R7: A group with no active lane issues no transaction, and done is 1 in the cycle after acceptance.
- R8: While txn_valid is 1 and txn_ready is 0, txn_base, txn_bytes and txn_mask hold their values.
- R9: A request is accepted only while req_ready is 1. req_ready is 0 from acceptance until the cycle after done.
- R10: done is a single-cycle pulse in the cycle after the last transaction handshake, with txn_valid at 0.
- R11: Every txn_base is aligned to its txn_bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | New group offered |
| req_ready | output | 1 | Block idle and able to take a group |
| req_addr | input | LANES*AW | Byte addresses, lane k in bits k*AW +: AW |
| req_active | input | LANES | Active bit per lane |
| req_wsize | input | 3 | Word size code |
| req_relaxed | input | 1 | 1 = segment-count rule, 0 = strict rule |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction taken |
| txn_base | output | AW | Transaction base byte address |
| txn_bytes | output | 8 | Transaction size in bytes |
| txn_mask | output | LANES | Lanes served by this transaction |
| done | output | 1 | Group fully served |

## Verification
The patterns used are a contiguous aligned block, the same block with two lanes swapped, a block shifted by one word, sparse active sets with garbage on inactive lanes, lanes spread over segments in descending order, every word size including an out-of-range code, and an empty group. Sending the contiguous, swapped and shifted blocks under both rules shows the strict fallback apart from relaxed segment counting. The sparse and descending cases check masking and issue order. Different ready patterns test that outputs are held while stalled.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FIN   = 2'd2
  } lc_state_e;

  // log2 of the word size in bytes; codes above 4 behave as 16-byte words
  function automatic logic [3:0] word_shift(input logic [2:0] code);
    return (code > 3'd4) ? 4'd4 : {1'b0, code};
  endfunction

  // log2 of the segment size: sixteen words, never beyond 128 bytes
  function automatic logic [3:0] seg_shift(input logic [2:0] code,
                                           input int unsigned lane_bits);
    logic [3:0] s;
    s = word_shift(code) + 4'(lane_bits);
    return (s > 4'd7) ? 4'd7 : s;
  endfunction

endpackage

// File: rtl/lc_strict_check.sv
module lc_strict_check #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    act,
  input  logic [3:0]          wsh,
  output logic                ok
);
  localparam int LIDX = $clog2(LANES);

  always_comb begin
    logic [AW-1:0] word_i;
    logic [AW-1:0] blk_i;
    logic [AW-1:0] blk_ref;
    logic          have;
    ok      = 1'b1;
    have    = 1'b0;
    blk_ref = '0;
    for (int i = 0; i < LANES; i++) begin
      word_i = addr[i*AW +: AW] >> wsh;
      blk_i  = word_i >> LIDX;
      if (act[i]) begin
        if (word_i[LIDX-1:0] != LIDX'(i)) ok = 1'b0;
        if (!have) begin
          blk_ref = blk_i;
          have    = 1'b1;
        end else if (blk_i != blk_ref) begin
          ok = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lc_seg_pick.sv
module lc_seg_pick #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    pend,
  input  logic [3:0]          ssh,
  output logic [AW-1:0]       base,
  output logic [LANES-1:0]    mask
);
  always_comb begin
    logic [AW-1:0] seg_i;
    logic [AW-1:0] best;
    logic          found;
    best  = '1;
    found = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      seg_i = addr[i*AW +: AW] >> ssh;
      if (pend[i] && (!found || seg_i < best)) begin
        best  = seg_i;
        found = 1'b1;
      end
    end
    mask = '0;
    for (int i = 0; i < LANES; i++) begin
      seg_i = addr[i*AW +: AW] >> ssh;
      if (pend[i] && seg_i == best) mask[i] = 1'b1;
    end
    base = best << ssh;
  end
endmodule

// File: rtl/lc_lane_pick.sv
module lc_lane_pick #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    pend,
  input  logic [3:0]          wsh,
  output logic [AW-1:0]       base,
  output logic [LANES-1:0]    mask
);
  localparam int LIDX = $clog2(LANES);

  logic [LIDX-1:0] sel;
  logic [AW-1:0]   sel_addr;

  always_comb begin
    sel = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) sel = LIDX'(i);
    end
  end

  assign sel_addr = addr[int'(sel)*AW +: AW];
  assign base     = (sel_addr >> wsh) << wsh;
  assign mask     = (pend == '0) ? '0 : (LANES'(1) << sel);
endmodule

// File: rtl/lane_coalescer.sv
module lane_coalescer
  import lc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES-1:0]    req_active,
  input  logic [2:0]          req_wsize,
  input  logic                req_relaxed,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_base,
  output logic [7:0]          txn_bytes,
  output logic [LANES-1:0]    txn_mask,
  output logic                done
);
  localparam int LIDX = $clog2(LANES);

  lc_state_e           state_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES-1:0]    pend_q;
  logic [3:0]          wsh_q;
  logic [3:0]          ssh_q;
  logic                per_lane_q;

  // named events used by the checker
  logic accept;
  logic txn_hs;
  logic strict_ok;
  logic [LANES-1:0] pend_next;

  logic [AW-1:0]    seg_base,  lane_base;
  logic [LANES-1:0] seg_mask,  lane_mask;

  lc_strict_check #(.LANES(LANES), .AW(AW)) u_strict (
    .addr (req_addr),
    .act  (req_active),
    .wsh  (word_shift(req_wsize)),
    .ok   (strict_ok)
  );

  lc_seg_pick #(.LANES(LANES), .AW(AW)) u_seg (
    .addr (addr_q),
    .pend (pend_q),
    .ssh  (ssh_q),
    .base (seg_base),
    .mask (seg_mask)
  );

  lc_lane_pick #(.LANES(LANES), .AW(AW)) u_lane (
    .addr (addr_q),
    .pend (pend_q),
    .wsh  (wsh_q),
    .base (lane_base),
    .mask (lane_mask)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign txn_valid = (state_q == ST_ISSUE);
  assign done      = (state_q == ST_FIN);
  assign accept    = req_valid && req_ready;
  assign txn_hs    = txn_valid && txn_ready;

  assign txn_base  = per_lane_q ? lane_base : seg_base;
  assign txn_mask  = per_lane_q ? lane_mask : seg_mask;
  assign txn_bytes = 8'(9'd1 << (per_lane_q ? wsh_q : ssh_q));
  assign pend_next = pend_q & ~txn_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      pend_q     <= '0;
      wsh_q      <= '0;
      ssh_q      <= '0;
      per_lane_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q     <= req_addr;
            pend_q     <= req_active;
            wsh_q      <= word_shift(req_wsize);
            ssh_q      <= seg_shift(req_wsize, LIDX);
            per_lane_q <= !req_relaxed && !strict_ok;
            state_q    <= (req_active == '0) ? ST_FIN : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (txn_hs) begin
            pend_q <= pend_next;
            if (pend_next == '0) state_q <= ST_FIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_coalescer_chk.sv
module lane_coalescer_chk #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic [LANES-1:0] req_active,
  input logic             accept,
  input logic             txn_hs,
  input logic             txn_valid,
  input logic             txn_ready,
  input logic [AW-1:0]    txn_base,
  input logic [7:0]       txn_bytes,
  input logic [LANES-1:0] txn_mask,
  input logic             done
);
  logic [AW-1:0] size_low;
  assign size_low = AW'(txn_bytes) - AW'(1);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_bytes) && $stable(txn_mask)); // R8
  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_mask != '0); // R3
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_base & size_low) == '0); // R11
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid || done) |-> !req_ready); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !txn_valid); // R10
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(txn_hs) || $past(accept)); // R10
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_active == '0 |=> done); // R7
endmodule

bind lane_coalescer lane_coalescer_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .req_active (req_active),
  .accept     (accept),
  .txn_hs     (txn_hs),
  .txn_valid  (txn_valid),
  .txn_ready  (txn_ready),
  .txn_base   (txn_base),
  .txn_bytes  (txn_bytes),
  .txn_mask   (txn_mask),
  .done       (done)
);

// File: tb/lane_coalescer_bench.sv
module lane_coalescer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int AW    = 32;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES-1:0]    req_active = '0;
  logic [2:0]          req_wsize = '0;
  logic                req_relaxed = 1'b0;
  logic                txn_valid;
  logic                txn_ready = 1'b0;
  logic [AW-1:0]       txn_base;
  logic [7:0]          txn_bytes;
  logic [LANES-1:0]    txn_mask;
  logic                done;

  int checks = 0;
  int failures = 0;
  logic [31:0] ta [LANES];

  logic [31:0] q_base [$];
  int          q_bytes [$];
  logic [15:0] q_mask [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_coalescer #(.LANES(LANES), .AW(AW)) u_lane_coalescer (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_active,
    .req_wsize, .req_relaxed, .txn_valid, .txn_ready, .txn_base,
    .txn_bytes, .txn_mask, .done
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, actual, expected);
    end
  endtask

  // behavioural reference: fills the expected transaction queues
  task automatic model(input int ws, input bit relaxed, input logic [15:0] act);
    int wsh, ssh;
    bit coal, have;
    logic [31:0] ref_blk, w, m;
    logic [15:0] served, msk;
    wsh = (ws > 4) ? 4 : ws;
    ssh = (wsh + 4 > 7) ? 7 : wsh + 4;
    coal = 1; have = 0; ref_blk = 0;
    for (int k = 0; k < LANES; k++) begin
      if (act[k]) begin
        w = ta[k] >> wsh;
        if ((w % 16) != k) coal = 0;
        if (!have) begin ref_blk = w / 16; have = 1; end
        else if (w / 16 != ref_blk) coal = 0;
      end
    end
    q_base.delete(); q_bytes.delete(); q_mask.delete();
    if (relaxed || coal) begin
      served = 0;
      while ((act & ~served) != 0) begin
        m = 32'hFFFF_FFFF;
        for (int k = 0; k < LANES; k++)
          if (act[k] && !served[k] && (ta[k] >> ssh) < m) m = ta[k] >> ssh;
        msk = 0;
        for (int k = 0; k < LANES; k++)
          if (act[k] && (ta[k] >> ssh) == m) msk[k] = 1'b1;
        q_base.push_back(m << ssh);
        q_bytes.push_back(1 << ssh);
        q_mask.push_back(msk);
        served |= msk;
      end
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (act[k]) begin
          q_base.push_back((ta[k] >> wsh) << wsh);
          q_bytes.push_back(1 << wsh);
          q_mask.push_back(16'(1 << k));
        end
      end
    end
  endtask

  task automatic run_case(input string tag, input int ws, input bit relaxed,
                          input logic [15:0] act, input int pat);
    int cyc;
    bit r, prev_r;
    model(ws, relaxed, act);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "req_ready idle", req_ready, 1);
    for (int k = 0; k < LANES; k++) req_addr[k*AW +: AW] = ta[k];
    req_active = act; req_wsize = 3'(ws); req_relaxed = relaxed; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (q_base.size() == 0) begin
      chk(done == 1'b1, "R7", "done on empty group", done, 1);
      chk(txn_valid == 1'b0, "R7", "no txn on empty group", txn_valid, 0);
      @(negedge clk);
      chk(done == 1'b0, "R10", "done single cycle", done, 0);
      chk(req_ready == 1'b1, "R9", "ready after done", req_ready, 1);
      return;
    end
    cyc = 0; prev_r = 1;
    while (q_base.size() > 0 && cyc < 4000) begin
      // after a stalled cycle the same front is compared again (R8)
      chk(txn_valid == 1'b1, prev_r ? tag : "R8", "txn_valid", txn_valid, 1);
      chk(txn_base == q_base[0], prev_r ? tag : "R8", "txn_base", txn_base, q_base[0]);
      chk(int'(txn_bytes) == q_bytes[0], prev_r ? tag : "R8", "txn_bytes", txn_bytes, q_bytes[0]);
      chk(txn_mask == q_mask[0], prev_r ? tag : "R6", "txn_mask", txn_mask, q_mask[0]);
      chk(req_ready == 1'b0 && done == 1'b0, "R9", "busy flags", {req_ready, done}, 0);
      r = (pat == 0) || (pat == 1 && cyc % 2 == 1) || (pat == 2 && cyc % 3 == 2);
      txn_ready = r;
      @(negedge clk);
      if (r) begin
        void'(q_base.pop_front()); void'(q_bytes.pop_front()); void'(q_mask.pop_front());
      end
      prev_r = r;
      cyc++;
    end
    txn_ready = 1'b0;
    chk(done == 1'b1, "R10", "done after last handshake", done, 1);
    chk(txn_valid == 1'b0, "R10", "no txn with done", txn_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single cycle", done, 0);
    chk(req_ready == 1'b1, "R9", "ready after done", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
    chk(txn_valid == 1'b0, "R1", "reset txn_valid", txn_valid, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    rst_n = 1'b1;

    // contiguous 32-bit block
    for (int k = 0; k < LANES; k++) ta[k] = 32'h1000 + 4*k;
    run_case("R3", 2, 1, 16'hFFFF, 0);
    run_case("R4", 2, 0, 16'hFFFF, 1);
    // lanes 0 and 1 swapped
    ta[0] = 32'h1004; ta[1] = 32'h1000;
    run_case("R5", 2, 0, 16'hFFFF, 0);
    run_case("R3", 2, 1, 16'hFFFF, 2);
    // shifted by one word: two segments when relaxed
    for (int k = 0; k < LANES; k++) ta[k] = 32'h1004 + 4*k;
    run_case("R5", 2, 0, 16'hFFFF, 1);
    run_case("R3", 2, 1, 16'hFFFF, 0);
    // sparse active lanes, garbage elsewhere
    for (int k = 0; k < LANES; k++) ta[k] = (k % 8 < 4) ? 32'h2200 + 4*k : 32'hDEAD_0000 + 12*k;
    run_case("R6", 2, 0, 16'h0F0F, 0);
    // 16-byte words: two 128-byte halves
    for (int k = 0; k < LANES; k++) ta[k] = 32'h2000 + 16*k;
    run_case("R4", 4, 0, 16'hFFFF, 0);
    run_case("R2", 5, 1, 16'hFFF0, 1);
    // byte, half-word and double-word sizes
    for (int k = 0; k < LANES; k++) ta[k] = 32'h3010 + k;
    run_case("R2", 0, 0, 16'hFFFF, 0);
    for (int k = 0; k < LANES; k++) ta[k] = 32'h3020 + 2*k + 1;
    run_case("R2", 1, 0, 16'hFFFF, 0);
    for (int k = 0; k < LANES; k++) ta[k] = 32'h4080 + 8*k;
    run_case("R2", 3, 0, 16'hFFFF, 2);
    // one segment per lane, descending addresses
    for (int k = 0; k < LANES; k++) ta[k] = 32'h8000 + 64*(15 - k);
    run_case("R3", 1, 1, 16'hFFFF, 1);
    // reversed order, sparse, strict: per-lane fallback on active lanes only
    for (int k = 0; k < LANES; k++) ta[k] = 32'h5000 + 4*(15 - k);
    run_case("R5", 2, 0, 16'h8421, 2);
    // empty group
    run_case("R7", 2, 1, 16'h0000, 0);
    run_case("R7", 2, 0, 16'h0000, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule